// File: doc/BRIEF.md
# Power-Management Event Controller

This block holds the fixed power-management event logic of a system controller. A free-running timer advances by one on every cycle where the tick-enable input is high. The tick is expected at the standard power-management timer rate of 3.579545 MHz. Four event sources each latch a sticky status bit: the timer's top bit changing, a power-button pulse, a global event and an RTC alarm. An enable register masks the four status bits. The block drives a registered, level-sensitive system control interrupt (SCI) whenever a latched status bit is also enabled.

A control word holds an SCI-enable flag, a suspend type and other stored bits. Writing the control word with the suspend strobe set and suspend type zero produces a one-cycle soft power-off request. An APM command/status byte pair lets firmware switch the SCI-enable flag on and off. Every command write also raises a one-cycle SMI pulse when the SMI-enable configuration input is high. All registers sit behind a simple word interface:
- writes take effect at the clock edge;
- reads are combinational on the offset.

Top module: `pm_event_ctrl`

## Requirements
- R1: The timer (TMR_W bits, default 24) increments by one on each clock where `tick_i` is high, holds otherwise, and wraps to zero; offset 3 reads timer bits 15:0 and offset 4 reads the bits above 15 (zero-extended).
- R2: Status bit 0 sets on the clock edge where timer bit TMR_W-1 changes value, whatever the enable register holds, and stays set until cleared; a crossing in the same cycle as a clear leaves it set.
- R3: The status register (offset 0) is write-one-to-clear on bits 0, 5, 8 and 10; writing 0 to a bit leaves it unchanged, and all other bits read 0.
- R4: A `pwrbtn_i` pulse sets status bit 8 only while enable bit 8 is set; `gbl_evt_i` sets bit 5 and `rtc_evt_i` sets bit 10 regardless of enables.
- R5: The enable register (offset 1) stores written bits 0, 5, 8 and 10 only; all other bits read 0.
- R6: `sci_o` is high in the cycle after any of bits 0, 5, 8, 10 is set in both status and enable, and low in the cycle after none is.
- R7: The control register (offset 2) stores every written bit except bit 13, which always reads 0.
- R8: A control write with bit 13 set and bits 12:10 equal to 0 raises `pwr_off_o` for exactly the following cycle; any other write leaves it low.
- R9: Writing 0xF1 to the APM command byte (offset 5) sets control bit 0, writing 0xF0 clears it, and any other value leaves it unchanged.
- R10: `smi_o` is high for the cycle after each APM command write made while `smi_en_i` is high, and low otherwise.
- R11: The APM command (offset 5) and APM status (offset 6) are 8-bit read/write bytes; offset 7 reads 0.
- R12: After reset the status, enable, control, timer and APM registers read 0, and `sci_o`, `smi_o` and `pwr_off_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick enable |
| pwrbtn_i | input | 1 | Power-button event pulse |
| gbl_evt_i | input | 1 | Global event pulse |
| rtc_evt_i | input | 1 | RTC alarm event pulse |
| smi_en_i | input | 1 | SMI enable configuration input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` |
| sci_o | output | 1 | Level-sensitive SCI |
| smi_o | output | 1 | One-cycle SMI pulse |
| pwr_off_o | output | 1 | One-cycle soft power-off request |

## Verification
The bench builds the block with TMR_W = 10, so the top timer bit changes every 512 ticks. Several overflow crossings then fit into a short run. This exposes the sticky overflow status, clear-then-rearm behaviour and the set-over-clear collision that a 24-bit timer would place millions of cycles away. ADDR_W stays at 3, which covers all seven offsets and the unused eighth. Random traffic is weighted toward the APM codes 0xF0 and 0xF1 and toward the power-off control pattern, so that these rare values occur often.

// File: rtl/pm_event_pkg.sv
package pm_event_pkg;

    localparam int DATA_W = 16;
    localparam int APM_W  = 8;

    // Event bit positions shared by status and enable
    localparam int B_TMR   = 0;
    localparam int B_GBL   = 5;
    localparam int B_PWR   = 8;
    localparam int B_RTC   = 10;
    localparam logic [DATA_W-1:0] EVT_MASK =
        DATA_W'((1 << B_TMR) | (1 << B_GBL) | (1 << B_PWR) | (1 << B_RTC));

    // Control word fields
    localparam int C_SCIEN  = 0;
    localparam int C_SUSLO  = 10;
    localparam int C_SUSHI  = 12;
    localparam int C_SUSSTB = 13;

    // APM command codes
    localparam logic [APM_W-1:0] APM_ON  = 8'hF1;
    localparam logic [APM_W-1:0] APM_OFF = 8'hF0;

    // Register offsets
    localparam int OFF_STS   = 0;
    localparam int OFF_EN    = 1;
    localparam int OFF_CTL   = 2;
    localparam int OFF_TLO   = 3;
    localparam int OFF_THI   = 4;
    localparam int OFF_CMD   = 5;
    localparam int OFF_APMS  = 6;

    typedef struct packed {
        logic [DATA_W-1:0] sts;
        logic [DATA_W-1:0] en;
        logic              sci;
    } evt_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic [APM_W-1:0]  cmd;
        logic [APM_W-1:0]  apms;
        logic              smi;
        logic              poff;
    } ctl_state_t;

endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [TMR_W-1:0] tmr_o,
    output logic             cross_o
);
    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tick_i) begin
            tmr_d = tmr_q + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tmr_o   = tmr_q;
    assign cross_o = tmr_q[MSB] ^ tmr_d[MSB];

endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
    import pm_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cross_i,
    input  logic              pwrbtn_i,
    input  logic              gbl_evt_i,
    input  logic              rtc_evt_i,
    input  logic              wr_sts_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] sts_o,
    output logic [DATA_W-1:0] en_o,
    output logic              sci_o
);
    evt_state_t s_d, s_q;

    always_comb begin
        logic [DATA_W-1:0] set_v;
        s_d = s_q;
        set_v = '0;
        set_v[B_TMR] = cross_i;
        set_v[B_GBL] = gbl_evt_i;
        set_v[B_PWR] = pwrbtn_i & s_q.en[B_PWR];
        set_v[B_RTC] = rtc_evt_i;
        if (wr_sts_i) begin
            s_d.sts = s_q.sts & ~(wdata_i & EVT_MASK);
        end
        s_d.sts = s_d.sts | set_v;
        if (wr_en_i) begin
            s_d.en = wdata_i & EVT_MASK;
        end
        s_d.sci = |(s_q.sts & s_q.en & EVT_MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sts_o = s_q.sts;
    assign en_o  = s_q.en;
    assign sci_o = s_q.sci;

endmodule

// File: rtl/pm_ctl_apm.sv
module pm_ctl_apm
    import pm_event_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl_i,
    input  logic              wr_cmd_i,
    input  logic              wr_apms_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              smi_en_i,
    output logic [DATA_W-1:0] ctl_o,
    output logic [APM_W-1:0]  cmd_o,
    output logic [APM_W-1:0]  apms_o,
    output logic              smi_o,
    output logic              pwr_off_o
);
    ctl_state_t c_d, c_q;

    always_comb begin
        logic [DATA_W-1:0] keep_mask;
        keep_mask = ~(DATA_W'(1) << C_SUSSTB);
        c_d      = c_q;
        c_d.smi  = 1'b0;
        c_d.poff = 1'b0;
        if (wr_ctl_i) begin
            c_d.ctl  = wdata_i & keep_mask;
            c_d.poff = wdata_i[C_SUSSTB] && (wdata_i[C_SUSHI:C_SUSLO] == 3'd0);
        end
        if (wr_cmd_i) begin
            c_d.cmd = wdata_i[APM_W-1:0];
            c_d.smi = smi_en_i;
            if (wdata_i[APM_W-1:0] == APM_ON) begin
                c_d.ctl[C_SCIEN] = 1'b1;
            end else if (wdata_i[APM_W-1:0] == APM_OFF) begin
                c_d.ctl[C_SCIEN] = 1'b0;
            end
        end
        if (wr_apms_i) begin
            c_d.apms = wdata_i[APM_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign ctl_o     = c_q.ctl;
    assign cmd_o     = c_q.cmd;
    assign apms_o    = c_q.apms;
    assign smi_o     = c_q.smi;
    assign pwr_off_o = c_q.poff;

endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_event_pkg::*;
#(
    parameter int TMR_W  = 24,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              pwrbtn_i,
    input  logic              gbl_evt_i,
    input  logic              rtc_evt_i,
    input  logic              smi_en_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o,
    output logic              sci_o,
    output logic              smi_o,
    output logic              pwr_off_o
);
    localparam int EXT_W = 2 * DATA_W;

    logic [TMR_W-1:0]  tmr_val;
    logic [EXT_W-1:0]  tmr_ext;
    logic              tmr_cross;
    logic [DATA_W-1:0] sts_val, en_val, ctl_val;
    logic [APM_W-1:0]  cmd_val, apms_val;
    logic              wr_sts, wr_en, wr_ctl, wr_cmd, wr_apms;

    assign wr_sts  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_STS));
    assign wr_en   = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_EN));
    assign wr_ctl  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CTL));
    assign wr_cmd  = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CMD));
    assign wr_apms = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_APMS));

    pm_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .tmr_o   (tmr_val),
        .cross_o (tmr_cross)
    );

    pm_evt_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cross_i   (tmr_cross),
        .pwrbtn_i  (pwrbtn_i),
        .gbl_evt_i (gbl_evt_i),
        .rtc_evt_i (rtc_evt_i),
        .wr_sts_i  (wr_sts),
        .wr_en_i   (wr_en),
        .wdata_i   (reg_wdata_i),
        .sts_o     (sts_val),
        .en_o      (en_val),
        .sci_o     (sci_o)
    );

    pm_ctl_apm u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl_i  (wr_ctl),
        .wr_cmd_i  (wr_cmd),
        .wr_apms_i (wr_apms),
        .wdata_i   (reg_wdata_i),
        .smi_en_i  (smi_en_i),
        .ctl_o     (ctl_val),
        .cmd_o     (cmd_val),
        .apms_o    (apms_val),
        .smi_o     (smi_o),
        .pwr_off_o (pwr_off_o)
    );

    assign tmr_ext = EXT_W'(tmr_val);

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_W'(OFF_STS):  reg_rdata_o = sts_val;
            ADDR_W'(OFF_EN):   reg_rdata_o = en_val;
            ADDR_W'(OFF_CTL):  reg_rdata_o = ctl_val;
            ADDR_W'(OFF_TLO):  reg_rdata_o = tmr_ext[DATA_W-1:0];
            ADDR_W'(OFF_THI):  reg_rdata_o = tmr_ext[EXT_W-1:DATA_W];
            ADDR_W'(OFF_CMD):  reg_rdata_o = DATA_W'(cmd_val);
            ADDR_W'(OFF_APMS): reg_rdata_o = DATA_W'(apms_val);
            default:           reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk #(
    parameter int TMR_W  = 24,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              pwrbtn_i,
    input logic              smi_en_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [15:0]       reg_wdata_i,
    input logic              smi_o,
    input logic              pwr_off_o,
    input logic [TMR_W-1:0]  tmr_val,
    input logic [15:0]       sts_val,
    input logic [15:0]       en_val,
    input logic [15:0]       ctl_val
);
    logic wr_sts_c, wr_ctl_c, wr_cmd_c;
    assign wr_sts_c = reg_wr_i && (reg_addr_i == ADDR_W'(0));
    assign wr_ctl_c = reg_wr_i && (reg_addr_i == ADDR_W'(2));
    assign wr_cmd_c = reg_wr_i && (reg_addr_i == ADDR_W'(5));

    p_tmr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> tmr_val == $past(tmr_val) + TMR_W'(1));

    p_tmr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(tmr_val));

    p_pb_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_i && !en_val[8] && !wr_sts_c && !sts_val[8]) |=> !sts_val[8]);

    p_pwroff_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_off_o |-> $past(wr_ctl_c && reg_wdata_i[13] && reg_wdata_i[12:10] == 3'd0));

    p_apm_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_c && reg_wdata_i[7:0] == 8'hF1) |=> ctl_val[0]);

    p_apm_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_c && reg_wdata_i[7:0] == 8'hF0) |=> !ctl_val[0]);

    p_smi_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smi_o |-> $past(wr_cmd_c && smi_en_i));

    p_susp_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_val[13]);

endmodule

bind pm_event_ctrl pm_event_ctrl_chk #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .pwrbtn_i    (pwrbtn_i),
    .smi_en_i    (smi_en_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .smi_o       (smi_o),
    .pwr_off_o   (pwr_off_o),
    .tmr_val     (tmr_val),
    .sts_val     (sts_val),
    .en_val      (en_val),
    .ctl_val     (ctl_val)
);

// File: tb/tb_pm_event_ctrl.sv
module tb_pm_event_ctrl;
    localparam int TW = 10;
    localparam int AW = 3;
    localparam logic [15:0] MASK = 16'h0521;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, pb = 0, gbl = 0, rtc = 0, smien = 0, wr = 0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic sci, smi, poff;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    logic [TW-1:0] m_tmr;
    logic [15:0] m_sts, m_en, m_ctl;
    logic [7:0] m_cmd, m_apms;
    logic m_sci, m_smi, m_poff;

    always #2 clk = ~clk;

    pm_event_ctrl #(.TMR_W(TW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pwrbtn_i(pb),
        .gbl_evt_i(gbl), .rtc_evt_i(rtc), .smi_en_i(smien),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .sci_o(sci), .smi_o(smi), .pwr_off_o(poff)
    );

    function automatic logic [15:0] exp_rd(input logic [AW-1:0] a);
        logic [31:0] t = 32'(m_tmr);
        case (a)
            3'd0: return m_sts;
            3'd1: return m_en;
            3'd2: return m_ctl;
            3'd3: return t[15:0];
            3'd4: return t[31:16];
            3'd5: return {8'h0, m_cmd};
            3'd6: return {8'h0, m_apms};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [AW-1:0] a);
        case (a)
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R7";
            3'd3, 3'd4: return "R1";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        m_tmr = '0; m_sts = '0; m_en = '0; m_ctl = '0;
        m_cmd = '0; m_apms = '0; m_sci = 0; m_smi = 0; m_poff = 0;
    endtask

    // one cycle: drive at negedge, compare before the edge, then advance model
    task automatic step(input logic w, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic t, input logic p, input logic g, input logic r,
                        input logic se);
        logic [TW-1:0] nt;
        logic [15:0] ns, nc;
        @(negedge clk);
        wr = w; addr = a; wdata = d; tick = t; pb = p; gbl = g; rtc = r; smien = se;
        #1;
        chk(req_of(a), rdata, exp_rd(a));
        chk("R6", 16'(sci), 16'(m_sci));
        chk("R10", 16'(smi), 16'(m_smi));
        chk("R8", 16'(poff), 16'(m_poff));
        @(posedge clk);
        nt = m_tmr + TW'(t);
        ns = m_sts;
        if (w && a == 3'd0) ns = ns & ~(d & MASK);
        if (nt[TW-1] != m_tmr[TW-1]) ns[0] = 1'b1;
        if (g) ns[5] = 1'b1;
        if (p && m_en[8]) ns[8] = 1'b1;
        if (r) ns[10] = 1'b1;
        nc = m_ctl;
        m_sci = |(m_sts & m_en & MASK);
        m_smi = w && a == 3'd5 && se;
        m_poff = w && a == 3'd2 && d[13] && d[12:10] == 3'd0;
        if (w && a == 3'd1) m_en = d & MASK;
        if (w && a == 3'd2) nc = d & 16'hDFFF;
        if (w && a == 3'd5) begin
            m_cmd = d[7:0];
            if (d[7:0] == 8'hF1) nc[0] = 1'b1;
            else if (d[7:0] == 8'hF0) nc[0] = 1'b0;
        end
        if (w && a == 3'd6) m_apms = d[7:0];
        m_tmr = nt; m_sts = ns; m_ctl = nc;
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) step(0, 3'd7, 16'h0, t, 0, 0, 0, 0);
    endtask

    initial begin
        int unsigned seed = 32'h5EED_1234;
        int unsigned r0;
        r0 = $urandom(seed);
        model_reset();
        repeat (3) @(posedge clk);
        // R12: values under and just after reset
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            addr = AW'(a); #1; chk("R12", rdata, 16'h0);
        end
        chk("R12", {13'h0, sci, smi, poff}, 16'h0);
        rst_n = 1'b1;

        // R5 / R3: enable mask and W1C
        step(1, 3'd1, 16'hFFFF, 0, 0, 0, 0, 0);
        step(0, 3'd1, 16'h0, 0, 0, 1, 1, 0);
        step(1, 3'd0, 16'h0000, 0, 1, 0, 0, 0);   // R3 zero write, R4 pb enabled
        step(0, 3'd0, 16'h0, 0, 0, 0, 0, 0);
        chk("R4", m_sts, 16'h0520);
        step(1, 3'd0, 16'hFFFF, 0, 0, 0, 0, 0);   // R3 clear all
        idle(2, 0);
        // R4: power button masked
        step(1, 3'd1, 16'h0000, 0, 0, 0, 0, 0);
        step(0, 3'd0, 16'h0, 0, 1, 0, 0, 0);
        step(0, 3'd0, 16'h0, 0, 0, 0, 0, 0);
        // R8: soft power-off and non-matching type
        step(1, 3'd2, 16'h2000, 0, 0, 0, 0, 0);
        step(1, 3'd2, 16'h2400, 0, 0, 0, 0, 0);
        step(0, 3'd2, 16'h0, 0, 0, 0, 0, 0);
        // R9 / R10: APM codes with and without SMI enable
        step(1, 3'd5, 16'h00F1, 0, 0, 0, 0, 1);
        step(1, 3'd5, 16'h0033, 0, 0, 0, 0, 0);
        step(1, 3'd5, 16'h00F0, 0, 0, 0, 0, 1);
        step(0, 3'd2, 16'h0, 0, 0, 0, 0, 0);
        // R2: overflow crossings, clear, set-over-clear collision
        step(1, 3'd1, 16'h0001, 0, 0, 0, 0, 0);
        idle(520, 1);
        chk("R2", m_sts & 16'h1, 16'h1);
        step(1, 3'd0, 16'h0001, 1, 0, 0, 0, 0);
        idle(500, 1);
        while (m_tmr != 10'h3FF) step(0, 3'd3, 16'h0, 1, 0, 0, 0, 0);
        step(1, 3'd0, 16'h0001, 1, 0, 0, 0, 0);   // clear on crossing cycle
        step(0, 3'd0, 16'h0, 0, 0, 0, 0, 0);
        chk("R2", m_sts & 16'h1, 16'h1);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic w; logic [AW-1:0] a; logic [15:0] d; int unsigned k;
            k = $urandom % 16;
            w = ($urandom % 3) == 0;
            a = AW'($urandom % 8);
            d = 16'($urandom);
            if (k == 0) d = 16'h00F1;
            if (k == 1) d = 16'h00F0;
            if (k == 2) d = {d[15:14], 1'b1, 3'b000, d[9:0]};
            step(w, a, d, ($urandom % 2) == 0, ($urandom % 12) == 0,
                 ($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 2) == 0);
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule